// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block holds the digital side of a 10-bit successive-approximation converter that serves eight multiplexed analog inputs. Software programs it through a small register window: one control register plus two read-only result registers. Once the converter is enabled, software picks a channel and sets the start bit. The block then latches the channel onto the multiplexer select. It spends one ADC clock in sample-and-hold and ten ADC clocks deciding the result bits, most significant first. During the decisions it drives a trial code to an external resistor DAC and reads back a single comparator bit.

The ADC clock is a one-cycle enable strobe on the system clock. At the end of a conversion the result is stored across a high and a low register and the start bit drops. An end-of-conversion flag is set and stays set until software clears it. An interrupt request follows that flag whenever the interrupt enable bit is set. If software clears the enable bit during a conversion, the conversion stops cleanly.

The DAC, the comparator, the analog multiplexer and the settling time after enabling sit outside this block. Here they exist only as ports.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After a synchronous reset every register reads 0, and `dac_code`, `sample_hold`, `chan_sel` and `irq` are 0.
- R2: A write to the control register (address 0) that has bit 3 (start) and bit 5 (enable) both at 1, made while idle, begins a conversion. From the next cycle, bit 3 reads 1 until the conversion ends. A start written with bit 5 at 0 starts nothing.
- R3: A conversion takes exactly 11 `adc_clk_en` strobes counted after the start write. `sample_hold` is high from the start until the first strobe. Each of the next ten strobes decides one bit, and the result is stored at the 11th strobe.
- R4: Bit decisions run from bit 9 down to bit 0. Each step drives the trial bit at 1 on `dac_code`. At the strobe, the bit is kept when `cmp_in` is 1 (input at or above the DAC level) and cleared otherwise. For a monotonic comparator the stored result equals the input code.
- R5: Address 1 reads result bits 9:2. Address 2 reads result bits 1:0 in its bits 1:0, with bits 7:2 at 0.
- R6: At completion, start (bit 3) reads 0 and the end-of-conversion flag (bit 4) reads 1. The flag stays 1 until a control write with bit 4 at 0. A control write with bit 4 at 1 never sets the flag.
- R7: `irq` is 1 exactly when the end-of-conversion flag and the interrupt enable (control bit 6) are both 1.
- R8: A start write while a conversion runs is ignored. The running conversion keeps its timing and its channel.
- R9: Control bits 2:0 hold the channel field and read back as written. Codes 0 to 7 select inputs 0 to 7 on `chan_sel`, which is loaded only when a conversion starts.
- R10: A control write with bit 5 at 0 during a conversion aborts it. From the next cycle the start bit is 0, `dac_code` and `sample_hold` are 0, the result registers are unchanged and the flag is not set.
- R11: Address 3 reads 0. Writes to addresses 1 to 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data of the addressed register |
| adc_clk_en | input | 1 | One-cycle ADC clock strobe |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code | output | 10 | Trial code to the resistor DAC |
| sample_hold | output | 1 | High during the sample-and-hold phase |
| chan_sel | output | 3 | Analog multiplexer select latched at start |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several boundaries. It checks inputs at zero, at full scale and at mid-scale; a controller that decided bits in the wrong order, or treated equality as "below", would store the wrong result there. It writes a new start and a new channel in the middle of a conversion, which exposes a design that restarted or resampled on the new channel. It clears the enable mid-conversion, which catches a design that still published a partial result or raised the flag. It counts strobes at two strobe rates to catch an off-by-one in the eleven-clock sequence. It also checks that a flag write with bit 4 at 1 preserves the flag and that a write with bit 4 at 0 clears it, so both the set and the clear paths are exercised.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } sar_state_t;

  // control register bit positions
  localparam int CB_START = 3;
  localparam int CB_EOC   = 4;
  localparam int CB_EN    = 5;
  localparam int CB_IE    = 6;

  // register addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_HI   = 1;
  localparam int ADDR_LO   = 2;
endpackage

// File: rtl/sar_adc_engine.sv
module sar_adc_engine
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int CHAN_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 abort,
  input  logic                 strobe,
  input  logic                 cmp,
  input  logic [CHAN_BITS-1:0] start_chan,
  output logic                 busy,
  output logic                 sampling,
  output logic                 done,
  output logic [RES_BITS-1:0]  final_code,
  output logic [RES_BITS-1:0]  code,
  output logic [CHAN_BITS-1:0] chan
);
  localparam int IDX_W = $clog2(RES_BITS);

  sar_state_t           state;
  logic [IDX_W-1:0]     idx;
  logic [RES_BITS-1:0]  code_q;
  logic [RES_BITS-1:0]  decided;

  // current trial bit resolved by the comparator
  always_comb begin
    decided      = code_q;
    decided[idx] = cmp;
  end

  assign done       = (state == ST_CONV) && strobe && (idx == '0) && !abort;
  assign final_code = decided;
  assign busy       = (state != ST_IDLE);
  assign sampling   = (state == ST_SAMPLE);
  assign code       = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      idx    <= '0;
      code_q <= '0;
      chan   <= '0;
    end else if (abort) begin
      state  <= ST_IDLE;
      code_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SAMPLE;
            code_q <= '0;
            chan   <= start_chan;
          end
        end
        ST_SAMPLE: begin
          if (strobe) begin
            state  <= ST_CONV;
            idx    <= IDX_W'(RES_BITS - 1);
            code_q <= {1'b1, {(RES_BITS-1){1'b0}}};
          end
        end
        ST_CONV: begin
          if (strobe) begin
            if (idx == '0) begin
              state  <= ST_IDLE;
              code_q <= decided;
            end else begin
              idx    <= idx - 1'b1;
              code_q <= decided | (RES_BITS'(1) << (idx - 1'b1));
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int CHAN_BITS = 3,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_ctrl,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 busy,
  input  logic                 done,
  input  logic [RES_BITS-1:0]  final_code,
  output logic                 start_req,
  output logic                 abort_req,
  output logic [CHAN_BITS-1:0] chan_f,
  output logic                 en_q,
  output logic                 ie_q,
  output logic                 eoc_q,
  output logic [RES_BITS-1:0]  result_q
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[DATA_W-1:CB_IE+1];

  assign start_req = wr_ctrl && wdata[CB_START] && wdata[CB_EN] && !busy;
  assign abort_req = wr_ctrl && !wdata[CB_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_f   <= '0;
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      eoc_q    <= 1'b0;
      result_q <= '0;
    end else begin
      if (wr_ctrl) begin
        chan_f <= wdata[CHAN_BITS-1:0];
        en_q   <= wdata[CB_EN];
        ie_q   <= wdata[CB_IE];
      end
      // software may only clear the flag; completion sets it and wins
      eoc_q <= ((wr_ctrl ? (eoc_q & wdata[CB_EOC]) : eoc_q)) | done;
      if (done) result_q <= final_code;
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int CHAN_BITS = 3,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic                 adc_clk_en,
  input  logic                 cmp_in,
  output logic [RES_BITS-1:0]  dac_code,
  output logic                 sample_hold,
  output logic [CHAN_BITS-1:0] chan_sel,
  output logic                 irq
);
  localparam int LO_BITS = RES_BITS - DATA_W;

  logic                 wr_ctrl;
  logic                 start_req, abort_req;
  logic                 busy, done;
  logic [RES_BITS-1:0]  final_code, result_q;
  logic [CHAN_BITS-1:0] chan_f;
  logic                 en_q, ie_q, eoc_q;
  logic [DATA_W-1:0]    ctrl_view, hi_view, lo_view;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(ADDR_CTRL));

  sar_adc_regs #(
    .RES_BITS(RES_BITS), .CHAN_BITS(CHAN_BITS), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .busy(busy), .done(done), .final_code(final_code),
    .start_req(start_req), .abort_req(abort_req), .chan_f(chan_f),
    .en_q(en_q), .ie_q(ie_q), .eoc_q(eoc_q), .result_q(result_q)
  );

  sar_adc_engine #(
    .RES_BITS(RES_BITS), .CHAN_BITS(CHAN_BITS)
  ) u_engine (
    .clk(clk), .rst(rst), .start(start_req), .abort(abort_req),
    .strobe(adc_clk_en), .cmp(cmp_in), .start_chan(wdata[CHAN_BITS-1:0]),
    .busy(busy), .sampling(sample_hold), .done(done),
    .final_code(final_code), .code(dac_code), .chan(chan_sel)
  );

  always_comb begin
    ctrl_view                  = '0;
    ctrl_view[CHAN_BITS-1:0]   = chan_f;
    ctrl_view[CB_START]        = busy;
    ctrl_view[CB_EOC]          = eoc_q;
    ctrl_view[CB_EN]           = en_q;
    ctrl_view[CB_IE]           = ie_q;
  end

  assign hi_view = result_q[RES_BITS-1 -: DATA_W];
  assign lo_view = DATA_W'(result_q[LO_BITS-1:0]);

  always_comb begin
    case (addr)
      ADDR_W'(ADDR_CTRL): rdata = ctrl_view;
      ADDR_W'(ADDR_HI):   rdata = hi_view;
      ADDR_W'(ADDR_LO):   rdata = lo_view;
      default:            rdata = '0;
    endcase
  end

  assign irq = eoc_q & ie_q;
endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int CHAN_BITS = 3,
  parameter int DATA_W    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_ctrl,
  input logic [DATA_W-1:0]    wdata,
  input logic                 busy,
  input logic                 done,
  input logic                 eoc,
  input logic                 sample,
  input logic                 strobe,
  input logic [RES_BITS-1:0]  result,
  input logic [CHAN_BITS-1:0] chan,
  input logic [RES_BITS-1:0]  dac
);
  logic abort_w;
  assign abort_w = wr_ctrl && !wdata[CB_EN];

  assert_sample_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    sample && strobe && !abort_w |=> busy && !sample);

  assert_eoc_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    eoc && !(wr_ctrl && !wdata[CB_EOC]) |=> eoc);

  assert_eoc_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc) |-> $past(busy) && !busy);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (rst)
    busy && !done && !abort_w |=> busy);

  assert_chan_held_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(chan));

  assert_result_only_on_done_R10: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(result));

  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (rst)
    abort_w |=> !busy && (dac == '0) && !sample);
endmodule

bind sar_adc_ctrl sar_adc_chk #(
  .RES_BITS(RES_BITS), .CHAN_BITS(CHAN_BITS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(wdata), .busy(busy),
  .done(done), .eoc(eoc_q), .sample(sample_hold), .strobe(adc_clk_en),
  .result(result_q), .chan(chan_sel), .dac(dac_code)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       adc_clk_en = 0;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic       sample_hold;
  logic [2:0] chan_sel;
  logic       irq;

  logic [9:0] ain [0:7];
  int checks = 0, fails = 0, stb_per = 1, div = 0, cyc = 0;
  bit finished = 0, counting = 0;
  int stb_cnt = 0;

  // reference model state
  int m_state, m_code, m_idx, m_chan, m_chf, m_en, m_ie, m_eoc, m_res;

  sar_adc_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .adc_clk_en(adc_clk_en), .cmp_in(cmp_in),
    .dac_code(dac_code), .sample_hold(sample_hold), .chan_sel(chan_sel), .irq(irq)
  );

  always #5 clk = ~clk;
  assign cmp_in = (ain[chan_sel] >= dac_code);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    div++;
    adc_clk_en = ((div % stb_per) == 0);
  end

  always @(posedge clk) if (counting && adc_clk_en) stb_cnt++;

  function automatic int model_rd(input int a);
    case (a)
      0: return m_chf | ((m_state != 0) << 3) | (m_eoc << 4) | (m_en << 5) | (m_ie << 6);
      1: return m_res >> 2;
      2: return m_res & 3;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit wc, dn;
    if (rst) begin
      m_state = 0; m_code = 0; m_idx = 0; m_chan = 0; m_chf = 0;
      m_en = 0; m_ie = 0; m_eoc = 0; m_res = 0;
    end else begin
      dn = 0;
      wc = wr_en && (addr == 0);
      if (wc && !wdata[5]) begin
        m_state = 0; m_code = 0;
      end else if (m_state == 0) begin
        if (wc && wdata[3] && wdata[5]) begin
          m_state = 1; m_code = 0; m_chan = int'(wdata[2:0]);
        end
      end else if (m_state == 1) begin
        if (adc_clk_en) begin m_state = 2; m_idx = 9; m_code = 512; end
      end else if (adc_clk_en) begin
        if (int'(ain[m_chan]) < m_code) m_code = m_code - (1 << m_idx);
        if (m_idx == 0) begin dn = 1; m_res = m_code; m_state = 0; end
        else begin m_idx--; m_code = m_code + (1 << m_idx); end
      end
      if (wc) begin
        m_chf = int'(wdata[2:0]); m_en = int'(wdata[5]); m_ie = int'(wdata[6]);
        m_eoc = m_eoc & int'(wdata[4]);
      end
      if (dn) m_eoc = 1;
    end
    #1;
    if (!rst && !finished) begin
      chk("R4 per-cycle dac_code", dac_code, m_code);
      chk("R3 per-cycle sample_hold", sample_hold, m_state == 1);
      chk("R9 per-cycle chan_sel", chan_sel, m_chan);
      chk("R7 per-cycle irq", irq, m_eoc & m_ie);
      chk("R5 per-cycle rdata", rdata, model_rd(addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog R3: actual %0d cycles expected done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = 2'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); addr = 2'(a); #1; v = rdata;
  endtask

  task automatic wait_done();
    int v;
    for (int i = 0; i < 400; i++) begin
      rd(0, v);
      if (v[4]) break;
    end
  endtask

  // start a conversion, confirm start/sample, count strobes to completion
  task automatic conv_count(input int d, output int cnt);
    @(negedge clk); wr_en = 1; addr = 0; wdata = 8'(d);
    @(posedge clk); #1; counting = 1; stb_cnt = 0;
    chk("R2 start bit reads 1", rdata[3], 1);
    chk("R3 sample_hold after start", sample_hold, 1);
    @(negedge clk); wr_en = 0;
    wait_done();
    counting = 0;
    cnt = stb_cnt;
  endtask

  initial begin
    int v, n;
    for (int i = 0; i < 8; i++) ain[i] = 10'(i * 100);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(0, v); chk("R1 ctrl reset", v, 0);
    rd(1, v); chk("R1 hi reset", v, 0);
    rd(2, v); chk("R1 lo reset", v, 0);
    chk("R1 dac reset", dac_code, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 sample reset", sample_hold, 0);

    // main conversion, strobe every 3 cycles
    stb_per = 3; ain[3] = 10'h2B7;
    conv_count(8'h6B, n);
    chk("R3 strobe count", n, 11);
    rd(0, v); chk("R6 ctrl after done", v, 8'h73);
    rd(1, v); chk("R5 hi", v, 8'hAD);
    rd(2, v); chk("R5 lo", v, 8'h03);
    chk("R7 irq set", irq, 1);

    // flag handling
    wr(0, 8'h33);
    chk("R7 irq masked", irq, 0);
    rd(0, v); chk("R6 flag kept by write of 1", v[4], 1);
    wr(0, 8'h23);
    rd(0, v); chk("R6 flag cleared by write of 0", v, 8'h23);

    // extremes and mid-scale
    stb_per = 1; ain[0] = 10'h000;
    conv_count(8'h68, n);
    chk("R3 strobe count fast", n, 11);
    rd(1, v); chk("R4 zero hi", v, 0);
    rd(2, v); chk("R4 zero lo", v, 0);
    ain[7] = 10'h3FF;
    conv_count(8'h6F, n);
    rd(1, v); chk("R4 full hi", v, 8'hFF);
    rd(2, v); chk("R4 full lo", v, 3);
    stb_per = 2; ain[5] = 10'h200;
    conv_count(8'h2D, n);
    rd(1, v); chk("R4 mid hi", v, 8'h80);
    rd(2, v); chk("R4 mid lo", v, 0);

    // start with enable low
    wr(0, 8'h09);
    rd(0, v); chk("R2 no start without enable", v, 8'h01);

    // restart and channel change during conversion
    ain[2] = 10'h155; ain[6] = 10'h0AA;
    wr(0, 8'h6A);
    repeat (5) @(negedge clk);
    wr(0, 8'h6E);
    chk("R9 chan_sel held", chan_sel, 2);
    rd(0, v); chk("R9 field reads new code", v, 8'h6E);
    wait_done();
    rd(1, v); chk("R8 hi from first channel", v, 8'h55);
    rd(2, v); chk("R8 lo from first channel", v, 1);

    // abort
    wr(0, 8'h6C);
    repeat (8) @(negedge clk);
    wr(0, 8'h04);
    rd(0, v); chk("R10 ctrl after abort", v, 8'h04);
    chk("R10 dac after abort", dac_code, 0);
    chk("R10 sample after abort", sample_hold, 0);
    repeat (40) @(negedge clk);
    rd(0, v); chk("R10 no flag", v[4], 0);
    rd(1, v); chk("R10 hi unchanged", v, 8'h55);
    rd(2, v); chk("R10 lo unchanged", v, 1);

    // address map
    wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF);
    rd(1, v); chk("R11 hi not writable", v, 8'h55);
    rd(2, v); chk("R11 lo not writable", v, 1);
    rd(3, v); chk("R11 addr 3 reads 0", v, 0);
    rd(0, v); chk("R11 ctrl untouched", v, 8'h04);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule